// File: doc/BRIEF.md
# Synchronized Edge-Capture Timer

This block counts ticks of a slow timer-clock input and records the current count when a chosen edge appears on a capture input. The whole block runs on one fast system clock. The timer-clock input and the capture input are sampled as ordinary data and pass through synchronizer flops. The counter runs from zero up to a programmable terminal value and then returns to zero. For example, a 10 kHz tick with a terminal value of 9999 gives one wrap per second.

A capture can be taken in one of two ways. In the direct way, the count is latched as soon as the capture edge is seen. In the aligned way, the capture is held pending until the next selected timer-clock edge. The selected edge is either the rising or the falling edge, which shifts the ambiguity window by half a tick.

An oversampled mode is intended for a timer clock that runs four times faster. In that mode the counter wraps at four times the base span and the reported value is divided by four. This reduces the one-count dither seen when the capture edge sits on a tick boundary. A sticky flag, an overrun flag and a one-cycle interrupt pulse report each capture.

Top module: `edge_capture_timer`

## Requirements
- R1: `count` advances by one on each synchronized rising edge of `tclk_in`. When it is at the effective terminal value, it returns to 0 on the next such edge, and it never exceeds that terminal value.
- R2: `edge_sel` picks the capture trigger: 0 = none, 1 = rising, 2 = falling, 3 = both edges of the synchronized `cap_in`. With 0, no capture ever occurs.
- R3: With `sync_en` low, the value of `count` is latched in the same system cycle in which the synchronized capture edge is detected.
- R4: With `sync_en` high, a capture waits until the next synchronized `tclk_in` edge chosen by `sample_fall` (0 = rising, 1 = falling). It then latches the count held before that edge updates the counter.
- R5: An aligned capture taken on the rising tick that wraps the counter records the terminal value, not 0.
- R6: With `oversample` high, the effective terminal value is 4*(`base_term`+1)-1, and `cap_value` reports the latched count shifted right by 2 bits. With it low, the terminal value is `base_term`.
- R7: Every capture sets `cap_flag`. A `flag_clr` pulse clears it. A capture in the same cycle as `flag_clr` leaves the flag set.
- R8: `cap_ovf` is set by a capture that arrives while `cap_flag` is set and not being cleared in that cycle. It is cleared only by `flag_clr` or reset.
- R9: When `irq_en` is high, each capture produces a one-cycle `cap_irq` pulse on the following cycle. When `irq_en` is low, no pulse is produced.
- R10: Synchronous `rst` clears the counter, the capture value, both flags, the pending capture and the interrupt.
- R11: `cap_value` never exceeds `base_term` in either mode, so a capture is always a legal adjacent count and never a corrupted one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous reset, active high |
| tclk_in | input | 1 | timer-clock input, sampled |
| cap_in | input | 1 | capture signal, sampled |
| base_term | input | CNT_W | base terminal count |
| edge_sel | input | 2 | capture trigger select |
| sync_en | input | 1 | align capture to a timer-clock edge |
| sample_fall | input | 1 | aligned capture on the falling timer edge |
| oversample | input | 1 | 4x count, result shifted right by 2 |
| irq_en | input | 1 | interrupt pulse enable |
| flag_clr | input | 1 | clears capture and overrun flags |
| count | output | CNT_W+2 | running counter |
| cap_value | output | CNT_W | reported capture value |
| cap_flag | output | 1 | capture happened |
| cap_ovf | output | 1 | capture overrun |
| cap_irq | output | 1 | one-cycle capture interrupt |

## Verification
On every cycle, the assertions check the counter range and wrap, the setting of the flags and the overrun, the interrupt that follows a capture, and that an aligned capture occurs only on the selected timer-clock edge. They also check that the reported value stays within the base range. Only the bench scenarios can show the exact values latched. These include the terminal value on a wrap-coincident aligned capture, the half-tick shift caused by the falling-phase select, the scaling in oversampled mode, and the silence when no trigger is selected. The bench shows these by comparing every output against its own cycle model.

// File: rtl/ect_pkg.sv
package ect_pkg;

  typedef enum logic [1:0] {
    TRIG_NONE = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_BOTH = 2'd3
  } trig_e;

  // effective terminal count for the chosen rate
  function automatic logic [31:0] ect_term(input logic [31:0] base, input logic ovs);
    return ovs ? (((base + 32'd1) << 2) - 32'd1) : base;
  endfunction

  // scale a raw latched count back to base resolution
  function automatic logic [31:0] ect_scale(input logic [31:0] raw, input logic ovs);
    return ovs ? (raw >> 2) : raw;
  endfunction

  // does this edge pair match the selected trigger
  function automatic logic ect_trig_hit(input trig_e sel, input logic rise, input logic fall);
    case (sel)
      TRIG_RISE: return rise;
      TRIG_FALL: return fall;
      TRIG_BOTH: return rise | fall;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ect_edge_sync.sv
module ect_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;
endmodule

// File: rtl/ect_counter.sv
module ect_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [CW-1:0] term,
  output logic [CW-1:0] count,
  output logic          wrap
);
  logic at_end;

  assign at_end = (count >= term);
  assign wrap   = tick & at_end;

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (tick)
      count <= at_end ? '0 : count + CW'(1);
  end
endmodule

// File: rtl/ect_capture.sv
module ect_capture
  import ect_pkg::*;
#(
  parameter int CNT_W = 14,
  parameter int CW    = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_en,
  input  logic             sample_fall,
  input  logic             oversample,
  input  logic             irq_en,
  input  logic             flag_clr,
  input  logic [1:0]       edge_sel,
  input  logic             t_rise,
  input  logic             t_fall,
  input  logic             c_rise,
  input  logic             c_fall,
  input  logic [CW-1:0]    count,
  output logic             cap_event,
  output logic             cap_fire,
  output logic [CNT_W-1:0] cap_value,
  output logic             cap_flag,
  output logic             cap_ovf,
  output logic             cap_irq
);
  logic pending;
  logic phase_tick;
  logic keep_flag;

  assign cap_event  = ect_trig_hit(trig_e'(edge_sel), c_rise, c_fall);
  assign phase_tick = sample_fall ? t_fall : t_rise;
  assign cap_fire   = sync_en ? (phase_tick & (pending | cap_event)) : cap_event;
  assign keep_flag  = cap_flag & ~flag_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending   <= 1'b0;
      cap_value <= '0;
      cap_flag  <= 1'b0;
      cap_ovf   <= 1'b0;
      cap_irq   <= 1'b0;
    end else begin
      if (!sync_en || cap_fire)
        pending <= 1'b0;
      else if (cap_event)
        pending <= 1'b1;
      if (cap_fire)
        cap_value <= CNT_W'(ect_scale(32'(count), oversample));
      cap_flag <= cap_fire | keep_flag;
      cap_ovf  <= (cap_fire & keep_flag) | (cap_ovf & ~flag_clr);
      cap_irq  <= cap_fire & irq_en;
    end
  end
endmodule

// File: rtl/edge_capture_timer.sv
module edge_capture_timer
  import ect_pkg::*;
#(
  parameter int CNT_W   = 14,
  parameter int SYNC_FF = 2,
  localparam int CW     = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tclk_in,
  input  logic             cap_in,
  input  logic [CNT_W-1:0] base_term,
  input  logic [1:0]       edge_sel,
  input  logic             sync_en,
  input  logic             sample_fall,
  input  logic             oversample,
  input  logic             irq_en,
  input  logic             flag_clr,
  output logic [CW-1:0]    count,
  output logic [CNT_W-1:0] cap_value,
  output logic             cap_flag,
  output logic             cap_ovf,
  output logic             cap_irq
);
  // named internal events for the checker
  logic          tclk_lvl, tclk_rise, tclk_fall;
  logic          capi_lvl, capi_rise, capi_fall;
  logic          cap_event, cap_fire, cnt_wrap;
  logic [CW-1:0] term_eff;

  assign term_eff = CW'(ect_term(32'(base_term), oversample));

  ect_edge_sync #(.STAGES(SYNC_FF)) u_tsync (
    .clk(clk), .rst(rst), .din(tclk_in),
    .level(tclk_lvl), .rise(tclk_rise), .fall(tclk_fall)
  );

  ect_edge_sync #(.STAGES(SYNC_FF)) u_csync (
    .clk(clk), .rst(rst), .din(cap_in),
    .level(capi_lvl), .rise(capi_rise), .fall(capi_fall)
  );

  ect_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .tick(tclk_rise), .term(term_eff),
    .count(count), .wrap(cnt_wrap)
  );

  ect_capture #(.CNT_W(CNT_W), .CW(CW)) u_cap (
    .clk(clk), .rst(rst), .sync_en(sync_en), .sample_fall(sample_fall),
    .oversample(oversample), .irq_en(irq_en), .flag_clr(flag_clr),
    .edge_sel(edge_sel), .t_rise(tclk_rise), .t_fall(tclk_fall),
    .c_rise(capi_rise), .c_fall(capi_fall), .count(count),
    .cap_event(cap_event), .cap_fire(cap_fire), .cap_value(cap_value),
    .cap_flag(cap_flag), .cap_ovf(cap_ovf), .cap_irq(cap_irq)
  );
endmodule

// File: rtl/ect_checker.sv
module ect_checker #(
  parameter int CNT_W = 14,
  localparam int CW   = CNT_W + 2
) (
  input logic             clk,
  input logic             rst,
  input logic             sync_en,
  input logic             sample_fall,
  input logic             irq_en,
  input logic             flag_clr,
  input logic [CNT_W-1:0] base_term,
  input logic [CW-1:0]    term_eff,
  input logic [CW-1:0]    count,
  input logic [CNT_W-1:0] cap_value,
  input logic             cap_flag,
  input logic             cap_ovf,
  input logic             cap_irq,
  input logic             tclk_rise,
  input logic             tclk_fall,
  input logic             cap_fire
);
  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    count <= term_eff);
  // R1
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tclk_rise && count == term_eff) |=> count == '0);
  // R4
  sync_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (sync_en && cap_fire) |-> (sample_fall ? tclk_fall : tclk_rise));
  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    cap_fire |=> cap_flag);
  // R8
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_fire && cap_flag && !flag_clr) |=> cap_ovf);
  // R8
  ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_ovf && !flag_clr) |=> cap_ovf);
  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_fire && irq_en) |=> cap_irq);
  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    cap_irq |=> !cap_irq || $past(cap_fire));
  // R11
  cap_range_chk: assert property (@(posedge clk) disable iff (rst)
    cap_flag |-> cap_value <= base_term);
endmodule

bind edge_capture_timer ect_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .sync_en(sync_en), .sample_fall(sample_fall),
  .irq_en(irq_en), .flag_clr(flag_clr), .base_term(base_term),
  .term_eff(term_eff), .count(count), .cap_value(cap_value),
  .cap_flag(cap_flag), .cap_ovf(cap_ovf), .cap_irq(cap_irq),
  .tclk_rise(tclk_rise), .tclk_fall(tclk_fall), .cap_fire(cap_fire)
);

// File: tb/edge_capture_timer_tb_top.sv
module edge_capture_timer_tb_top;
  localparam int CNT_W = 14;
  localparam int CW    = CNT_W + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tclk_in = 1'b0, cap_in = 1'b0;
  logic [CNT_W-1:0] base_term = 14'd4;
  logic [1:0] edge_sel = 2'd1;
  logic sync_en = 0, sample_fall = 0, oversample = 0, irq_en = 0, flag_clr = 0;
  logic [CW-1:0] count;
  logic [CNT_W-1:0] cap_value;
  logic cap_flag, cap_ovf, cap_irq;

  always #2.5 clk = ~clk;

  edge_capture_timer #(.CNT_W(CNT_W)) dut_i (.*);

  int vectors = 0, errors = 0;
  int th = 4;
  string tag = "R10";

  // timer-clock stimulus, half period th system cycles
  always begin
    repeat (th) @(negedge clk);
    tclk_in = ~tclk_in;
  end

  // behavioural reference model
  int m_t[3], m_c[3];
  int m_cnt, m_val, m_flag, m_ovf, m_irq, m_pend;
  bit hit_term = 0, seen_wrap = 0;

  always @(posedge clk) begin
    int tr, tf, cr, cf, ev, fire, term, keep, ph;
    if (rst) begin
      m_t = '{0, 0, 0}; m_c = '{0, 0, 0};
      m_cnt = 0; m_val = 0; m_flag = 0; m_ovf = 0; m_irq = 0; m_pend = 0;
    end else begin
      tr = (m_t[1] == 1 && m_t[2] == 0); tf = (m_t[1] == 0 && m_t[2] == 1);
      cr = (m_c[1] == 1 && m_c[2] == 0); cf = (m_c[1] == 0 && m_c[2] == 1);
      ev = (edge_sel == 1) ? cr : (edge_sel == 2) ? cf : (edge_sel == 3) ? (cr | cf) : 0;
      term = oversample ? (int'(base_term) + 1) * 4 - 1 : int'(base_term);
      ph = sample_fall ? tf : tr;
      fire = sync_en ? (ph && (m_pend || ev)) : ev;
      m_pend = (sync_en && !fire) ? (m_pend | ev) : 0;
      keep = m_flag && !flag_clr;
      if (fire) m_val = oversample ? (m_cnt / 4) : m_cnt;
      m_ovf = (fire && keep) || (m_ovf && !flag_clr);
      m_flag = fire || keep;
      m_irq = fire && irq_en;
      if (tr) m_cnt = (m_cnt >= term) ? 0 : m_cnt + 1;
      m_t[2] = m_t[1]; m_t[1] = m_t[0]; m_t[0] = int'(tclk_in);
      m_c[2] = m_c[1]; m_c[1] = m_c[0]; m_c[0] = int'(cap_in);
    end
  end

  // per-cycle comparison away from the active edge
  int prev_cnt = 0;
  always @(negedge clk) begin
    if (!rst) begin
      vectors++;
      if (int'(count) != m_cnt || int'(cap_value) != m_val || int'(cap_flag) != m_flag ||
          int'(cap_ovf) != m_ovf || int'(cap_irq) != m_irq) begin
        errors++;
        $display("FAIL %s: act cnt=%0d val=%0d flg=%0d ovf=%0d irq=%0d exp cnt=%0d val=%0d flg=%0d ovf=%0d irq=%0d",
                 tag, count, cap_value, cap_flag, cap_ovf, cap_irq,
                 m_cnt, m_val, m_flag, m_ovf, m_irq);
      end
      if (tag == "R5" && cap_flag && cap_value == base_term) hit_term = 1;
      if (prev_cnt == int'(base_term) && count == 0 && !oversample) seen_wrap = 1;
      prev_cnt = int'(count);
    end
  end

  task automatic chk(string t, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act %0d exp %0d", t, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int w, int gap);
    cap_in = 1'b1; cyc(w); cap_in = 1'b0; cyc(gap);
  endtask

  task automatic clr_flags();
    flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; cyc(3); rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: act hung exp done");
    finish_run();
  end

  initial begin
    cyc(4);
    // R10 reset state
    chk("R10 count", int'(count), 0);
    chk("R10 flag", int'(cap_flag), 0);
    chk("R10 irq", int'(cap_irq), 0);
    rst = 1'b0;

    // R1 counting and wrap, R3 direct capture, R9 irq
    tag = "R3"; irq_en = 1;
    for (int k = 0; k < 12; k++) begin pulse(3, 17 + k); clr_flags(); end
    chk("R1 wrap seen", int'(seen_wrap), 1);

    // R8 overrun, R7 clear
    tag = "R8";
    pulse(3, 10); pulse(3, 10);
    chk("R8 ovf", int'(cap_ovf), 1);
    clr_flags(); cyc(1);
    tag = "R7";
    chk("R7 flag cleared", int'(cap_flag), 0);
    chk("R7 ovf cleared", int'(cap_ovf), 0);

    // R2 no trigger
    tag = "R2"; edge_sel = 2'd0;
    for (int k = 0; k < 4; k++) pulse(4, 9);
    chk("R2 none", int'(cap_flag), 0);
    edge_sel = 2'd2;
    for (int k = 0; k < 6; k++) begin pulse(5, 11 + k); clr_flags(); end
    edge_sel = 2'd3; irq_en = 0;
    tag = "R9";
    for (int k = 0; k < 6; k++) begin pulse(7, 13 + k); clr_flags(); end
    chk("R9 no irq", int'(cap_irq), 0);
    irq_en = 1;

    // R4/R5 aligned capture, rising phase; sweep relative offset
    tag = "R5"; edge_sel = 2'd1; sync_en = 1;
    for (int k = 0; k < 45; k++) begin pulse(2, 39); clr_flags(); end
    chk("R5 terminal captured", int'(hit_term), 1);

    // R4 falling phase
    tag = "R4"; sample_fall = 1;
    for (int k = 0; k < 30; k++) begin pulse(2, 37); clr_flags(); end
    sample_fall = 0;

    // R6 oversampled rate, R11 range
    tag = "R6"; do_reset(); oversample = 1; th = 1; base_term = 14'd4;
    for (int k = 0; k < 25; k++) begin pulse(2, 9 + k); clr_flags(); end
    sync_en = 0;
    for (int k = 0; k < 25; k++) begin
      pulse(2, 7 + k);
      chk("R11 range", int'(cap_value <= base_term), 1);
      clr_flags();
    end

    // R10 mid-run reset
    tag = "R10"; pulse(2, 5);
    rst = 1'b1; cyc(1);
    chk("R10 count", int'(count), 0);
    chk("R10 value", int'(cap_value), 0);
    chk("R10 flag", int'(cap_flag), 0);
    chk("R10 ovf", int'(cap_ovf), 0);
    rst = 1'b0; cyc(20);
    finish_run();
  end
endmodule